// File: doc/BRIEF.md
# Alarm, Clock-Out and Interrupt Controller

This block sits beside the time-of-day counters of a real-time clock. It holds three write-only alarm registers for seconds, minutes and hours. When the alarm is enabled and the counters reach the stored time, it records an alarm event. It also picks one of fifteen square-wave taps from the prescaler and counter chain, drives that tap onto a clock-out pin, and records a clock event on each falling edge of the selected tap.

Either event pulls an active-low interrupt line low and sets a flag in a status byte. Bit 7 is the alarm flag and bit 6 is the clock flag. The flags stay set until a control-register write or a reset clears them.

A power-down input does three things: it forces the clock-out pin low, releases the interrupt pin's output enable, and blocks bus-side writes. While it is low, both event sources still set their flags and can still pull the interrupt line low.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: With `clk_sel` = 0 and `pdown_n` high, `clk_out` is 1 whatever the taps do.
- R2: With `clk_sel` = k (1..15) and `pdown_n` high, `clk_out` equals `tap_vec[k-1]` in the same cycle.
- R3: A 1-to-0 change of `tap_vec[k-1]` while `clk_sel` = k sets status bit 6 and drives `irq_n` low from the next cycle. A rising edge of the selected tap has no effect. A falling edge of an unselected tap has no effect. No tap has any effect when `clk_sel` = 0.
- R4: When `alarm_en` is 1 and all three counter fields match the alarm registers, status bit 7 is set and `irq_n` goes low in the next cycle. The condition only sets the flag when it becomes true, so a match that continues after a clear does not set the flag again.
- R5: While `alarm_en` is 0, a match sets nothing. If `alarm_en` then rises while the counters still match, the flag is set.
- R6: The hours comparison ignores bit 6 of the alarm hours register. Bit 7 (AM/PM) is compared only when bit 6 of `cnt_hr` is 1 (12-hour mode). Bits 5:0 are always compared. Seconds and minutes are compared on all 8 bits.
- R7: A `ctrl_wr` pulse with `pdown_n` high clears both status flags and releases `irq_n` in the next cycle. The clear wins over any event in the same cycle.
- R8: Reset (`rst_n` low) clears the status flags, sets `irq_n` to 1, loads the hours alarm register with 8'h30 and loads the seconds and minutes alarm registers with 0.
- R9: Status bits 5:0 always read 0.
- R10: While `pdown_n` is low, `clk_out` is 0 and `irq_oe` is 0. Alarm and clock events still set their flags.
- R11: While `pdown_n` is low, `alm_wr` and `ctrl_wr` are ignored.
- R12: A status flag stays set until a clear from R7 or a reset.
- R13: `alm_wr` bit 0 writes `alm_wdata` into the seconds alarm register, bit 1 into the minutes register and bit 2 into the hours register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_sec | input | 8 | Live seconds counter, BCD |
| cnt_min | input | 8 | Live minutes counter, BCD |
| cnt_hr | input | 8 | Live hours counter; bit 7 is AM/PM, bit 6 is the 12-hour mode flag |
| tap_vec | input | NUM_TAPS | Square-wave taps; tap i is chosen by select code i+1 |
| clk_sel | input | SEL_W | Clock-out select code, 0 = off |
| ctrl_wr | input | 1 | Control-register write pulse (clears status) |
| alm_wr | input | 3 | Alarm register write strobes: bit 0 seconds, bit 1 minutes, bit 2 hours |
| alm_wdata | input | 8 | Alarm register write data |
| alarm_en | input | 1 | Alarm enable |
| pdown_n | input | 1 | Active-low power-down |
| clk_out | output | 1 | Selected square wave |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Interrupt pin output enable; 0 means tri-stated |
| status | output | 8 | Status byte: bit 7 alarm flag, bit 6 clock flag |

## Verification
The checker tests several rules on every clock cycle:
- the zero low bits of the status byte;
- the fixed relation between `irq_n` and the two flags;
- the forced levels of `clk_out` and `irq_oe` during power-down;
- the resting-high output with the select at zero;
- the clear that follows a control write;
- the persistence of the flags.

Only the bench scenarios can show which events set a flag. These include the selected tap's falling edge versus its rising edge or other taps, the one-shot behaviour of the alarm match, the masking of AM/PM in 24-hour mode, the 8'h30 reset value of the hours register, and writes being dropped during power-down.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_FIELD = 3;

    typedef enum logic [1:0] {
        FLD_SEC = 2'd0,
        FLD_MIN = 2'd1,
        FLD_HR  = 2'd2
    } field_e;

    localparam logic [BYTE_W-1:0] HR_ALARM_RST = 8'h30;

    typedef struct packed {
        logic [N_FIELD-1:0][BYTE_W-1:0] alm;
        logic                           st_alarm;
        logic                           st_tick;
        logic                           hit;
    } ctl_state_t;

endpackage

// File: rtl/tap_select.sv
module tap_select #(
    parameter int NUM_TAPS = 15,
    parameter int SEL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] tap_vec,
    input  logic [SEL_W-1:0]    sel,
    output logic                sel_level,
    output logic                sel_fall
);

    logic [NUM_TAPS-1:0] tap_d, tap_q;

    always_comb begin
        tap_d     = tap_vec;
        sel_level = 1'b1;
        sel_fall  = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                sel_level = tap_vec[i];
                sel_fall  = tap_q[i] & ~tap_vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_d;
    end

endmodule

// File: rtl/field_cmp.sv
module field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] care,
    output logic         eq
);

    always_comb begin
        eq = (((cnt ^ latch) & care) == '0);
    end

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int NUM_TAPS = 15,
    localparam int SEL_W   = $clog2(NUM_TAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTE_W-1:0]    cnt_sec,
    input  logic [BYTE_W-1:0]    cnt_min,
    input  logic [BYTE_W-1:0]    cnt_hr,
    input  logic [NUM_TAPS-1:0]  tap_vec,
    input  logic [SEL_W-1:0]     clk_sel,
    input  logic                 ctrl_wr,
    input  logic [N_FIELD-1:0]   alm_wr,
    input  logic [BYTE_W-1:0]    alm_wdata,
    input  logic                 alarm_en,
    input  logic                 pdown_n,
    output logic                 clk_out,
    output logic                 irq_n,
    output logic                 irq_oe,
    output logic [BYTE_W-1:0]    status
);

    localparam int HR_AMPM_BIT = BYTE_W - 1;
    localparam int HR_MODE_BIT = BYTE_W - 2;

    ctl_state_t st_d, st_q;

    logic sel_level, sel_fall;
    logic [BYTE_W-1:0] cnt_arr  [N_FIELD];
    logic [BYTE_W-1:0] care_arr [N_FIELD];
    logic [N_FIELD-1:0] eq_vec;
    logic bus_ok, hit_now;

    tap_select #(
        .NUM_TAPS(NUM_TAPS),
        .SEL_W   (SEL_W)
    ) u_tap_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_vec  (tap_vec),
        .sel      (clk_sel),
        .sel_level(sel_level),
        .sel_fall (sel_fall)
    );

    always_comb begin
        cnt_arr[FLD_SEC] = cnt_sec;
        cnt_arr[FLD_MIN] = cnt_min;
        cnt_arr[FLD_HR]  = cnt_hr;
    end

    // Hours: mode bit never compared, AM/PM compared only in 12-hour mode.
    for (genvar f = 0; f < N_FIELD; f++) begin : g_field
        if (f == int'(FLD_HR)) begin : g_hr
            always_comb begin
                care_arr[f]              = '1;
                care_arr[f][HR_MODE_BIT] = 1'b0;
                care_arr[f][HR_AMPM_BIT] = cnt_hr[HR_MODE_BIT];
            end
        end else begin : g_plain
            always_comb care_arr[f] = '1;
        end

        field_cmp #(.W(BYTE_W)) u_cmp (
            .cnt  (cnt_arr[f]),
            .latch(st_q.alm[f]),
            .care (care_arr[f]),
            .eq   (eq_vec[f])
        );
    end

    always_comb begin
        st_d    = st_q;
        bus_ok  = pdown_n;
        hit_now = alarm_en & (&eq_vec);

        for (int f = 0; f < N_FIELD; f++) begin
            if (bus_ok && alm_wr[f]) st_d.alm[f] = alm_wdata;
        end

        st_d.hit = hit_now;
        if (hit_now && !st_q.hit) st_d.st_alarm = 1'b1;
        if (sel_fall)             st_d.st_tick  = 1'b1;

        if (bus_ok && ctrl_wr) begin
            st_d.st_alarm = 1'b0;
            st_d.st_tick  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.alm[FLD_HR]  <= HR_ALARM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        clk_out = pdown_n & sel_level;
        irq_oe  = pdown_n;
        irq_n   = ~(st_q.st_alarm | st_q.st_tick);
        status  = {st_q.st_alarm, st_q.st_tick, {(BYTE_W-2){1'b0}}};
    end

endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] clk_sel,
    input logic             ctrl_wr,
    input logic             pdown_n,
    input logic             clk_out,
    input logic             irq_n,
    input logic             irq_oe,
    input logic [7:0]       status
);

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:0] == 6'd0);                                            // R9

    AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(status[7] || status[6]));                             // R3

    AST_PDOWN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !pdown_n |-> (!clk_out && !irq_oe));                             // R10

    AST_SEL_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown_n && clk_sel == '0) |-> clk_out);                         // R1

    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pdown_n) |=> (status[7:6] == 2'b00 && irq_n));       // R7

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !(ctrl_wr && pdown_n)) |=> status[7]);             // R12

    AST_TICK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !(ctrl_wr && pdown_n)) |=> status[6]);             // R12

endmodule

bind alarm_irq_ctrl alarm_irq_chk #(.SEL_W(SEL_W)) u_alarm_irq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_sel(clk_sel),
    .ctrl_wr(ctrl_wr),
    .pdown_n(pdown_n),
    .clk_out(clk_out),
    .irq_n  (irq_n),
    .irq_oe (irq_oe),
    .status (status)
);

// File: tb/test_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module test_alarm_irq_ctrl;

    localparam int NT = 15;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    cnt_sec, cnt_min, cnt_hr;
    logic [NT-1:0] tap_vec;
    logic [SW-1:0] clk_sel;
    logic          ctrl_wr;
    logic [2:0]    alm_wr;
    logic [7:0]    alm_wdata;
    logic          alarm_en;
    logic          pdown_n;
    logic          clk_out, irq_n, irq_oe;
    logic [7:0]    status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    alarm_irq_ctrl #(.NUM_TAPS(NT)) i_alarm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cnt_sec(cnt_sec), .cnt_min(cnt_min),
        .cnt_hr(cnt_hr), .tap_vec(tap_vec), .clk_sel(clk_sel),
        .ctrl_wr(ctrl_wr), .alm_wr(alm_wr), .alm_wdata(alm_wdata),
        .alarm_en(alarm_en), .pdown_n(pdown_n), .clk_out(clk_out),
        .irq_n(irq_n), .irq_oe(irq_oe), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_status();
        ctrl_wr = 1'b1; tick(); ctrl_wr = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; cnt_sec = 8'h00; cnt_min = 8'h00; cnt_hr = 8'h12;
        tap_vec = '0; clk_sel = '0; ctrl_wr = 1'b0; alm_wr = '0;
        alm_wdata = '0; alarm_en = 1'b0; pdown_n = 1'b1;
        tick(); tick(); tick();
        // R8 reset state
        chk("R8 status", status, 8'h00);
        chk("R8 irq_n", irq_n, 1);
        chk("R8 irq_oe", irq_oe, 1);
        rst_n = 1'b1; alarm_en = 1'b1; tick();
        chk("R8 no match at 12h", status, 8'h00);
        // R8 hours register resets to 30, sec/min to 0
        cnt_hr = 8'h30; tick();
        chk("R8 R4 reset latch match", status, 8'h80);
        chk("R4 irq_n low", irq_n, 0);
        cnt_hr = 8'h31; tick(); tick();
        chk("R12 alarm flag held", status, 8'h80);
        clear_status(); #1;
        chk("R7 cleared", status, 8'h00);
        chk("R7 irq_n high", irq_n, 1);
        // R4 edge qualification
        cnt_hr = 8'h30; tick();
        chk("R4 set again", status, 8'h80);
        clear_status(); tick();
        chk("R4 no re-set on held match", status, 8'h00);
        // R7 clear wins over same-cycle alarm
        cnt_hr = 8'h31; tick();
        cnt_hr = 8'h30; ctrl_wr = 1'b1; tick(); ctrl_wr = 1'b0;
        chk("R7 clear beats set", status, 8'h00);
        tick();
        chk("R7 R4 no late set", status, 8'h00);
        // R5 enable gating
        cnt_hr = 8'h31; alarm_en = 1'b0; tick();
        cnt_hr = 8'h30; tick(); tick();
        chk("R5 disabled no set", status, 8'h00);
        alarm_en = 1'b1; tick();
        chk("R5 enable rise sets", status, 8'h80);
        alarm_en = 1'b0; cnt_hr = 8'h31; clear_status();

        // R1 R2 select sweep
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 2; p++) begin
                clk_sel = SW'(s);
                tap_vec = (s == 0) ? (p ? '1 : '0)
                                   : (p ? ~(NT'(1) << (s-1)) : (NT'(1) << (s-1)));
                #1;
                if (s == 0) chk("R1 off rests high", clk_out, 1);
                else        chk("R2 tap follow", clk_out, (p == 0) ? 1 : 0);
                tick();
            end
        end
        tap_vec = '1; tick(); clear_status(); tick();

        // R3 falling edge sweep
        for (int k = 1; k <= NT; k++) begin
            clk_sel = SW'(k);
            tap_vec = '1; tick(); clear_status();
            tap_vec = ~(NT'(1) << (k % NT)); tick();
            chk("R3 other tap ignored", status, 8'h00);
            tap_vec = '1; tick();
            chk("R3 rise ignored", status, 8'h00);
            tap_vec = ~(NT'(1) << (k-1)); tick();
            chk("R3 fall sets clock flag", status, 8'h40);
            chk("R3 irq_n low", irq_n, 0);
        end
        clk_sel = '0; tap_vec = '1; tick(); clear_status();
        tap_vec = '0; tick();
        chk("R3 sel0 no event", status, 8'h00);

        // R10 R11 power-down
        clk_sel = SW'(1); tap_vec = '1; alarm_en = 1'b1; cnt_hr = 8'h31; tick();
        pdown_n = 1'b0; #1;
        chk("R10 clk_out low", clk_out, 0);
        chk("R10 irq_oe off", irq_oe, 0);
        alm_wr = 3'b001; alm_wdata = 8'h07; tick(); alm_wr = '0;
        cnt_hr = 8'h30; tick();
        chk("R10 R11 alarm in pd, old latch", status, 8'h80);
        clear_status();
        chk("R11 ctrl_wr ignored", status, 8'h80);
        tap_vec = '0; tick();
        chk("R10 clock flag in pd", status, 8'hC0);
        chk("R10 irq_n low in pd", irq_n, 0);
        pdown_n = 1'b1; clear_status();
        chk("R7 cleared after pd", status, 8'h00);
        clk_sel = '0;
        cnt_hr = 8'h31; tick();
        cnt_sec = 8'h07; cnt_hr = 8'h30; tick();
        chk("R11 latch write dropped", status, 8'h00);

        // R13 R6 hours sweep
        cnt_sec = 8'h59; tick();
        alm_wr = 3'b011; alm_wdata = 8'h00; tick(); alm_wr = '0;
        for (int m = 0; m < 2; m++)
          for (int cb = 0; cb < 2; cb++)
            for (int ab = 0; ab < 2; ab++)
              for (int a6 = 0; a6 < 2; a6++)
                for (int lo = 0; lo < 2; lo++) begin
                    logic [7:0] a, c;
                    bit exp_m;
                    a = {ab[0], a6[0], 6'h11};
                    c = {cb[0], m[0], (lo ? 6'h12 : 6'h11)};
                    exp_m = (a[5:0] == c[5:0]) && (m == 0 || ab == cb);
                    cnt_sec = 8'h59; clear_status();
                    alm_wr = 3'b100; alm_wdata = a; tick(); alm_wr = '0;
                    cnt_sec = 8'h00; cnt_min = 8'h00; cnt_hr = c; tick();
                    chk("R6 R13 hours compare", status, exp_m ? 8'h80 : 8'h00);
                end
        // R13 minutes register
        cnt_sec = 8'h59; clear_status();
        alm_wr = 3'b010; alm_wdata = 8'h42; tick(); alm_wr = '0;
        cnt_sec = 8'h00; cnt_min = 8'h42; cnt_hr = 8'h11; tick();
        chk("R13 minutes write", status, 8'h80);

        done = 1;
        report();
    end

endmodule